// File: doc/BRIEF.md
# Dual-Rail Full Adder with Latched Alarm

This block adds two multi-bit operands carried on dual-rail wires, together with a dual-rail carry input, and returns a dual-rail sum and carry-out. Each bit position is a full-adder cell. The cell first decodes its three input pairs into one of eight minterms through three-input C-elements. It then forms the sum and carry rails with a plain OR plane. Because exactly one minterm fires for each valid input word, every data value takes the same number of gate stages and toggles the same number of wires.

Each cell watches its three input pairs for the forbidden code where both rails are high. When it sees that code, a reset-dominant set/reset latch captures it and is ORed into every output rail. The alarm then travels up the carry chain and holds the affected outputs at the forbidden code until reset. A bitwise dual-rail OR lane uses the same alarm scheme, so that an alarm on either operand drives both of its result rails high. C-elements and latches are modelled as registers clocked by `clk_i`. Operands are applied as a valid word, held until the result settles, and then returned to all-null before the next word.

Top module: `dr_ripple_adder`

## Requirements
- R1: While `rst_ni` is low, and on the first edge after its release, every output pair is null (00) and `alarm_o` is 0.
- R2: Each pair is {rail1, rail0}. 01 (bit 0 high) means logic 0, 10 means logic 1, 00 means null and 11 means alarm. For any valid operands a, b and cin, `sum_o`/`cout_o` encode a+b+cin within WIDTH rising edges. No output pair is ever 11 unless `alarm_o` is 1.
- R3: Starting from null, output pair k of `sum_o` leaves null on exactly the (k+1)-th rising edge after valid operands appear, whatever the data. `cout_o` leaves null on the WIDTH-th edge.
- R4: When all inputs are null and no alarm is latched, every output pair returns to null within WIDTH rising edges.
- R5: An alarm code on bit k of `a_i` or `b_i` drives sum pairs k to WIDTH-1 and `cout_o` to 11 and sets `alarm_o`. Sum pairs below k still show the correct sum.
- R6: A latched alarm persists after the inputs return to null: the alarmed pairs and `alarm_o` stay high until `rst_ni` is asserted, and that reset clears them.
- R7: An alarm code on `cin_i` drives every sum pair and `cout_o` to 11.
- R8: Lane k of `or_o` encodes a[k] OR b[k] one rising edge after both operands are valid, for every data value.
- R9: An alarm on either operand of an OR lane drives both rails of that lane high, including rail0 when the other operand is logic 1. Other lanes are not affected.
- R10: If only some inputs of a cell return to null, its minterms hold, so every output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock that advances C-elements and latches |
| rst_ni | input | 1 | Asynchronous active-low reset, clears alarms |
| a_i | input | 2*WIDTH | Operand A, pair k at bits [2k+1:2k] |
| b_i | input | 2*WIDTH | Operand B, same layout |
| cin_i | input | 2 | Carry in pair |
| sum_o | output | 2*WIDTH | Sum pairs |
| cout_o | output | 2 | Carry out pair |
| or_o | output | 2*WIDTH | Bitwise dual-rail OR of A and B |
| alarm_o | output | 1 | OR of every cell's latched alarm |

## Verification
Every binary operand pair and both carry values are applied, each followed by a null spacer. This covers every minterm of every cell, carries that ripple the full length, and confirms that each word clears back to null. A few operand words, from all-zero to full carry propagation, are also stepped one edge at a time to show that the settling front moves one position per edge independent of data. Alarm codes are injected on each bit of each operand and on the carry input. This separates the pairs that must spread the alarm from the lower pairs that must keep correct data. A partial return to null shows that the C-elements hold their state.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef logic [1:0] dr_t;
  localparam dr_t DR_NULL  = 2'b00;
  localparam dr_t DR_ZERO  = 2'b01;
  localparam dr_t DR_ONE   = 2'b10;
  localparam dr_t DR_ALARM = 2'b11;
endpackage

// File: rtl/dr_celem.sv
module dr_celem #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic         q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          q_o <= 1'b0;
    else if (&in_i)       q_o <= 1'b1;
    else if (!(|in_i))    q_o <= 1'b0;
  end
endmodule

// File: rtl/dr_alarm_latch.sv
module dr_alarm_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic q_o
);
  // reset wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
  end
endmodule

// File: rtl/dr_full_adder.sv
module dr_full_adder
  import dr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  dr_t  a_i,
  input  dr_t  b_i,
  input  dr_t  cin_i,
  output dr_t  sum_o,
  output dr_t  cout_o,
  output logic alarm_o
);
  localparam int NMT = 8;
  logic [NMT-1:0] mt;
  logic           alarm_q;

  // minterm m picks rail m[2] of a, m[1] of b, m[0] of cin
  for (genvar m = 0; m < NMT; m++) begin : g_mt
    localparam int RA = (m >> 2) & 1;
    localparam int RB = (m >> 1) & 1;
    localparam int RC = m & 1;
    dr_celem #(.N(3)) u_c (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   ({a_i[RA], b_i[RB], cin_i[RC]}),
      .q_o    (mt[m])
    );
  end

  dr_alarm_latch u_alarm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ((&a_i) | (&b_i) | (&cin_i)),
    .q_o    (alarm_q)
  );

  always_comb begin
    logic s0, s1, c0, c1;
    s0 = 1'b0; s1 = 1'b0; c0 = 1'b0; c1 = 1'b0;
    for (int m = 0; m < NMT; m++) begin
      if ($countones(3'(m)) % 2 == 1) s1 |= mt[m];
      else                            s0 |= mt[m];
      if ($countones(3'(m)) >= 2)     c1 |= mt[m];
      else                            c0 |= mt[m];
    end
    sum_o  = {s1 | alarm_q, s0 | alarm_q};
    cout_o = {c1 | alarm_q, c0 | alarm_q};
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/dr_or_cell.sv
module dr_or_cell
  import dr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  dr_t  a_i,
  input  dr_t  b_i,
  output dr_t  r_o,
  output logic alarm_o
);
  logic [3:0] mt;
  logic       alarm_q;

  for (genvar m = 0; m < 4; m++) begin : g_mt
    localparam int RA = (m >> 1) & 1;
    localparam int RB = m & 1;
    dr_celem #(.N(2)) u_c (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .in_i   ({a_i[RA], b_i[RB]}),
      .q_o    (mt[m])
    );
  end

  dr_alarm_latch u_alarm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ((&a_i) | (&b_i)),
    .q_o    (alarm_q)
  );

  assign r_o     = {mt[1] | mt[2] | mt[3] | alarm_q, mt[0] | alarm_q};
  assign alarm_o = alarm_q;
endmodule

// File: rtl/dr_ripple_adder.sv
module dr_ripple_adder
  import dr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*WIDTH-1:0] a_i,
  input  logic [2*WIDTH-1:0] b_i,
  input  logic [1:0]         cin_i,
  output logic [2*WIDTH-1:0] sum_o,
  output logic [1:0]         cout_o,
  output logic [2*WIDTH-1:0] or_o,
  output logic               alarm_o
);
  dr_t              carry [WIDTH+1];
  logic [WIDTH-1:0] fa_alarm;
  logic [WIDTH-1:0] or_alarm;

  assign carry[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    dr_t s, r;
    dr_full_adder u_fa (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .a_i     (a_i[2*k +: 2]),
      .b_i     (b_i[2*k +: 2]),
      .cin_i   (carry[k]),
      .sum_o   (s),
      .cout_o  (carry[k+1]),
      .alarm_o (fa_alarm[k])
    );
    dr_or_cell u_or (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .a_i     (a_i[2*k +: 2]),
      .b_i     (b_i[2*k +: 2]),
      .r_o     (r),
      .alarm_o (or_alarm[k])
    );
    assign sum_o[2*k +: 2] = s;
    assign or_o[2*k +: 2]  = r;
  end

  assign cout_o  = carry[WIDTH];
  assign alarm_o = (|fa_alarm) | (|or_alarm);
endmodule

// File: rtl/dr_ripple_adder_chk.sv
module dr_ripple_adder_chk #(
  parameter int WIDTH = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2*WIDTH-1:0] a_i,
  input logic [2*WIDTH-1:0] b_i,
  input logic [1:0]         cin_i,
  input logic [2*WIDTH-1:0] sum_o,
  input logic [1:0]         cout_o,
  input logic [2*WIDTH-1:0] or_o,
  input logic               alarm_o
);
  localparam int CW = $clog2(WIDTH + 2);
  logic          in_alarm, out_alarm, in_null;
  logic [CW-1:0] null_cnt;

  always_comb begin
    in_alarm  = &cin_i;
    out_alarm = &cout_o;
    for (int k = 0; k < WIDTH; k++) begin
      in_alarm  |= (&a_i[2*k +: 2]) | (&b_i[2*k +: 2]);
      out_alarm |= (&sum_o[2*k +: 2]) | (&or_o[2*k +: 2]);
    end
    in_null = (a_i == '0) && (b_i == '0) && (cin_i == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     null_cnt <= '0;
    else if (!in_null)               null_cnt <= '0;
    else if (null_cnt < CW'(WIDTH))  null_cnt <= null_cnt + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (sum_o == '0 && cout_o == '0 && or_o == '0 && !alarm_o)
        else $error("R1 outputs not clear in reset");
    end
  end

  assert_alarm_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |=> alarm_o);

  assert_input_alarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_alarm |=> alarm_o);

  assert_no_false_alarm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_alarm |-> alarm_o);

  assert_null_return_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (null_cnt >= CW'(WIDTH) && !alarm_o) |-> (sum_o == '0 && cout_o == '0 && or_o == '0));
endmodule

bind dr_ripple_adder dr_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .or_o    (or_o),
  .alarm_o (alarm_o)
);

// File: tb/dr_ripple_adder_bench.sv
module dr_ripple_adder_bench;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  typedef struct {
    logic [PW-1:0] sum;
    logic [1:0]    cout;
    logic [PW-1:0] orv;
    logic          alarm;
    string         req;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [PW-1:0] a_i = '0, b_i = '0;
  logic [1:0]    cin_i = '0;
  logic [PW-1:0] sum_o, or_o;
  logic [1:0]    cout_o;
  logic          alarm_o;

  int   total = 0, bad = 0;
  exp_t q[$];
  event chk_ev;

  always #10 clk_i = ~clk_i;

  dr_ripple_adder #(.WIDTH(W)) u_dr_ripple_adder (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .sum_o(sum_o), .cout_o(cout_o), .or_o(or_o), .alarm_o(alarm_o)
  );

  function automatic logic [PW-1:0] enc(input logic [W-1:0] v);
    logic [PW-1:0] r;
    for (int k = 0; k < W; k++) r[2*k +: 2] = v[k] ? 2'b10 : 2'b01;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [PW-1:0] s, input logic [1:0] c, input logic [PW-1:0] o,
                      input logic al, input string req);
    exp_t e;
    e.sum = s; e.cout = c; e.orv = o; e.alarm = al; e.req = req;
    q.push_back(e);
    ->chk_ev;
  endtask

  // monitor
  initial forever begin
    exp_t e;
    @(chk_ev);
    e = q.pop_front();
    chk(sum_o == e.sum,     {e.req, " sum"},   64'(sum_o),   64'(e.sum));
    chk(cout_o == e.cout,   {e.req, " cout"},  64'(cout_o),  64'(e.cout));
    chk(or_o == e.orv,      {e.req, " or"},    64'(or_o),    64'(e.orv));
    chk(alarm_o == e.alarm, {e.req, " alarm"}, 64'(alarm_o), 64'(e.alarm));
  end

  task automatic apply(input logic [PW-1:0] a, input logic [PW-1:0] b, input logic [1:0] c);
    @(negedge clk_i);
    a_i = a; b_i = b; cin_i = c;
    repeat (W) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; a_i = '0; b_i = '0; cin_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  bit done = 0;
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    @(negedge clk_i);
    chk(sum_o == '0 && cout_o == '0 && or_o == '0 && !alarm_o, "R1 in reset",
        64'({sum_o, cout_o, or_o, alarm_o}), 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    push('0, 2'b00, '0, 1'b0, "R1 after release");

    // R3: settling front, one pair per edge
    for (int t = 0; t < 3; t++) begin
      logic [W-1:0] av, bv;
      av = (t == 0) ? 4'h0 : (t == 1) ? 4'hF : 4'h9;
      bv = (t == 0) ? 4'h0 : (t == 1) ? 4'h1 : 4'h6;
      @(negedge clk_i);
      a_i = enc(av); b_i = enc(bv); cin_i = 2'b01;
      for (int j = 1; j <= W; j++) begin
        @(negedge clk_i);
        for (int k = 0; k < W; k++)
          chk((sum_o[2*k +: 2] != 2'b00) == (k < j), "R3 front",
              64'(sum_o), 64'(j));
        chk((cout_o != 2'b00) == (j == W), "R3 cout front", 64'(cout_o), 64'(j));
        chk(or_o == (enc(av | bv)), "R8 or one edge", 64'(or_o), 64'(enc(av | bv)));
      end
      apply('0, '0, 2'b00);
    end

    // R2/R4/R8: exhaustive, each word followed by null spacer
    for (int ai = 0; ai < 16; ai++)
      for (int bi = 0; bi < 16; bi++)
        for (int ci = 0; ci < 2; ci++) begin
          logic [W:0] s;
          s = 5'(ai) + 5'(bi) + 5'(ci);
          apply(enc(4'(ai)), enc(4'(bi)), ci ? 2'b10 : 2'b01);
          push(enc(s[W-1:0]), s[W] ? 2'b10 : 2'b01, enc(4'(ai) | 4'(bi)), 1'b0, "R2 R8 data");
          apply('0, '0, 2'b00);
          push('0, 2'b00, '0, 1'b0, "R4 null");
        end

    // R10: partial null holds
    apply(enc(4'h5), enc(4'h3), 2'b01);
    push(enc(4'h8), 2'b01, enc(4'h7), 1'b0, "R10 base");
    apply('0, enc(4'h3), 2'b01);
    push(enc(4'h8), 2'b01, enc(4'h7), 1'b0, "R10 hold");
    apply('0, '0, 2'b00);
    push('0, 2'b00, '0, 1'b0, "R10 clear");

    // R5/R6/R9: alarm on bit k of a or b
    for (int side = 0; side < 2; side++)
      for (int k = 0; k < W; k++) begin
        logic [W-1:0] av, bv;
        logic [W:0]   s;
        logic [PW-1:0] a, b, es, eo, es2, eo2;
        av = 4'hA; bv = 4'hF;
        s  = 5'(av) + 5'(bv);
        a = enc(av); b = enc(bv);
        if (side == 0) a[2*k +: 2] = 2'b11; else b[2*k +: 2] = 2'b11;
        es = enc(s[W-1:0]); eo = enc(av | bv);
        es2 = '0; eo2 = '0;
        for (int j = k; j < W; j++) begin es[2*j +: 2] = 2'b11; es2[2*j +: 2] = 2'b11; end
        eo[2*k +: 2] = 2'b11; eo2[2*k +: 2] = 2'b11;
        do_reset();
        apply(a, b, 2'b01);
        push(es, 2'b11, eo, 1'b1, "R5 R9 alarm spread");
        apply('0, '0, 2'b00);
        push(es2, 2'b11, eo2, 1'b1, "R6 deadlock");
        do_reset();
        @(negedge clk_i);
        push('0, 2'b00, '0, 1'b0, "R6 reset clears");
      end

    // R7: alarm on carry in
    do_reset();
    apply(enc(4'h3), enc(4'h4), 2'b11);
    push({PW{1'b1}}, 2'b11, enc(4'h7), 1'b1, "R7 cin alarm");
    do_reset();
    @(negedge clk_i);
    push('0, 2'b00, '0, 1'b0, "R7 reset clears");

    @(negedge clk_i);
    finish_run();
  end
endmodule